// File: doc/BRIEF.md
# Operand Range Detector for a Split Functional Unit

This block sits next to a functional unit whose upper slice can be switched off. For every operand pair that is about to be loaded, it decides whether the result fits in the lower slice. If it fits, the upper slice is skipped and the result is rebuilt by sign extension. The block looks at the operands on the data side of the operand registers. Because of this, its decision to close the guard is ready before the new data reaches the guard storage on the upper inputs.

Two outputs come out. `sel_guard` opens (1) or closes (0) the guard storage on the upper-slice inputs. A close may act at once, within the cycle that loads the operands. An open waits for the rising clock edge, so a disabled upper slice never sees a short enable pulse. `sel_ext` is the registered decision for the operands now held in the registers. It changes only just after a clock edge, and it drives the sign-extension multiplexers on the result. When no load is requested, the last decision is kept.

An adder variant tests both operands against one shared upper-slice width. A multiplier variant tests each operand against its own bound, and it can try up to three bound pairs at once.

Top module: `opr_range_detect`

## Requirements
- R1: While `rst` is high at a rising edge, both `sel_guard` and `sel_ext` are 1 after that edge (full computation).
- R2: Adder mode: an operand pair fits when, in each operand, the top NM+1 bits (bit N-1 down to bit N-1-NM) are all 0 or all 1.
- R3: Multiplier mode: pair p (p < NPAIR) is met when the top KA_p+1 bits of `opa_d` are uniform and the top KB_p+1 bits of `opb_d` are uniform, each operand tested on its own. The pair fits when any pair is met. The defaults are (KA,KB) = (3,5), (4,4), (5,3) with N=16.
- R4: While `load` is 1 and the operands fit, `sel_guard` is 0 in that same cycle, before the clock edge.
- R5: While `sel_ext` is 0, `sel_guard` stays 0, even when non-fitting operands are being loaded. It returns to 1 only after the rising edge that loads them.
- R6: After a rising edge with `load` = 1, `sel_ext` is 0 if the loaded pair fit and 1 otherwise.
- R7: While `load` is 0 the operands are ignored: `sel_guard` equals `sel_ext`, and `sel_ext` does not change at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Operand register load request |
| opa_d | input | N | First operand, data side of its register |
| opb_d | input | N | Second operand, data side of its register |
| sel_guard | output | 1 | Upper-slice guard enable, 1 = open |
| sel_ext | output | 1 | Registered decision, 1 = full result, 0 = sign-extend lower slice |

## Verification
Operands are drawn from several groups: small positive and small negative values, values just past the shared boundary, and values with no spare sign bits. One group is chosen so that it meets only the first or only the last multiplier bound pair. Each pattern is applied to both variants together. The first group separates the pair-wise test from the shared-width test. The pair-specific group shows that each operand is held to its own bound, and not to a summed sign-region length. Sequences of closing loads, opening loads and idle cycles with changing operands show the two timing rules apart. A close takes effect before the edge, an open waits for the edge, and idle cycles keep the decision.

// File: rtl/opr_range_pkg.sv
package opr_range_pkg;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_MUL = 1'b1
    } unit_mode_e;

    localparam int MAX_PAIRS = 3;

    // Decision request presented to the guard controller
    typedef struct packed {
        logic load;
        logic fits;
    } range_verdict_t;

    function automatic int pick3(input int idx, input int v0, input int v1, input int v2);
        return (idx == 0) ? v0 : ((idx == 1) ? v1 : v2);
    endfunction

endpackage

// File: rtl/opr_sign_probe.sv
module opr_sign_probe #(
    parameter int N = 16,
    parameter int K = 8
) (
    input  logic [N-1:0] word,
    output logic         uniform
);
    localparam int LO = N - 1 - K;

    logic [K:0] head;

    assign head    = word[N-1:LO];
    assign uniform = (&head) | ~(|head);
endmodule

// File: rtl/opr_fit_eval.sv
module opr_fit_eval
    import opr_range_pkg::*;
#(
    parameter int         N     = 16,
    parameter int         NM    = 8,
    parameter unit_mode_e MODE  = MODE_MUL,
    parameter int         NPAIR = 3,
    parameter int         KA0   = 3,
    parameter int         KB0   = 5,
    parameter int         KA1   = 4,
    parameter int         KB1   = 4,
    parameter int         KA2   = 5,
    parameter int         KB2   = 3
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    output logic         fits
);
    generate
        if (MODE == MODE_ADD) begin : g_add
            logic ua, ub;
            opr_sign_probe #(.N(N), .K(NM)) u_pa (.word(opa), .uniform(ua));
            opr_sign_probe #(.N(N), .K(NM)) u_pb (.word(opb), .uniform(ub));
            assign fits = ua & ub;
        end else begin : g_mul
            logic [NPAIR-1:0] hit;
            for (genvar p = 0; p < NPAIR; p++) begin : g_pair
                localparam int KA = pick3(p, KA0, KA1, KA2);
                localparam int KB = pick3(p, KB0, KB1, KB2);
                logic ua, ub;
                opr_sign_probe #(.N(N), .K(KA)) u_pa (.word(opa), .uniform(ua));
                opr_sign_probe #(.N(N), .K(KB)) u_pb (.word(opb), .uniform(ub));
                assign hit[p] = ua & ub;
            end
            assign fits = |hit;
        end
    endgenerate
endmodule

// File: rtl/opr_guard_ctl.sv
module opr_guard_ctl
    import opr_range_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  range_verdict_t verdict,
    output logic           sel_guard,
    output logic           sel_ext
);
    logic held_q;

    // Decision for the operands now in the registers; kept when no load
    always_ff @(posedge clk) begin
        if (rst)
            held_q <= 1'b1;
        else if (verdict.load)
            held_q <= ~verdict.fits;
    end

    // Closing acts at once; opening waits for held_q to rise at the edge
    always_comb begin
        if (verdict.load && verdict.fits)
            sel_guard = 1'b0;
        else
            sel_guard = held_q;
    end

    assign sel_ext = held_q;
endmodule

// File: rtl/opr_range_detect.sv
module opr_range_detect
    import opr_range_pkg::*;
#(
    parameter int         N     = 16,
    parameter int         NM    = 8,
    parameter unit_mode_e MODE  = MODE_MUL,
    parameter int         NPAIR = 3,
    parameter int         KA0   = 3,
    parameter int         KB0   = 5,
    parameter int         KA1   = 4,
    parameter int         KB1   = 4,
    parameter int         KA2   = 5,
    parameter int         KB2   = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] opa_d,
    input  logic [N-1:0] opb_d,
    output logic         sel_guard,
    output logic         sel_ext
);
    logic           fits;
    range_verdict_t verdict;

    opr_fit_eval #(
        .N(N), .NM(NM), .MODE(MODE), .NPAIR(NPAIR),
        .KA0(KA0), .KB0(KB0), .KA1(KA1), .KB1(KB1), .KA2(KA2), .KB2(KB2)
    ) u_fit (
        .opa (opa_d),
        .opb (opb_d),
        .fits(fits)
    );

    assign verdict.load = load;
    assign verdict.fits = fits;

    opr_guard_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .sel_guard(sel_guard),
        .sel_ext  (sel_ext)
    );
endmodule

// File: rtl/opr_range_detect_chk.sv
module opr_range_detect_chk (
    input logic clk,
    input logic rst,
    input logic load,
    input logic sel_guard,
    input logic sel_ext
);
    a_r1_reset_full: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> sel_ext);

    a_r4_close_now: assert property (@(posedge clk) disable iff (rst)
        (load && sel_ext && !sel_guard) |=> !sel_ext);

    a_r5_no_early_open: assert property (@(posedge clk) disable iff (rst)
        !sel_ext |-> !sel_guard);

    a_r5_open_at_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_guard) |-> $rose(sel_ext));

    a_r6_open_load_full: assert property (@(posedge clk) disable iff (rst)
        (load && sel_guard) |=> sel_ext);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(sel_ext));

    a_r7_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !load |-> (sel_guard == sel_ext));
endmodule

bind opr_range_detect opr_range_detect_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .sel_guard(sel_guard),
    .sel_ext  (sel_ext)
);

// File: tb/sim_opr_range_detect.sv
module sim_opr_range_detect;
    import opr_range_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int NM = 8;

    typedef struct packed {
        logic         ld;
        logic [N-1:0] a;
        logic [N-1:0] b;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{1'b1, 16'h0005, 16'h0003},
        '{1'b1, 16'hFFF0, 16'h0010},
        '{1'b1, 16'h0100, 16'h0001},
        '{1'b1, 16'h7FFF, 16'h0001},
        '{1'b1, 16'h0080, 16'hFF7F},
        '{1'b0, 16'h7FFF, 16'h8000},
        '{1'b1, 16'h1000, 16'h0800},
        '{1'b1, 16'h0800, 16'h0400},
        '{1'b1, 16'h0400, 16'h0800},
        '{1'b1, 16'h0200, 16'h0200},
        '{1'b0, 16'h0000, 16'h0000},
        '{1'b1, 16'hF000, 16'hFFFF},
        '{1'b1, 16'h0001, 16'hC000},
        '{1'b1, 16'h007F, 16'hFF80},
        '{1'b0, 16'h4000, 16'h0001},
        '{1'b1, 16'h0000, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load = 1'b0;
    logic [N-1:0] opa = '0;
    logic [N-1:0] opb = '0;
    logic g0, e0, g1, e1;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;
    bit s0 = 1;
    bit s1 = 1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    opr_range_detect #(.N(N), .NM(NM), .MODE(MODE_MUL)) u0 (
        .clk(clk), .rst(rst), .load(load), .opa_d(opa), .opb_d(opb),
        .sel_guard(g0), .sel_ext(e0)
    );

    opr_range_detect #(.N(N), .NM(NM), .MODE(MODE_ADD)) u1 (
        .clk(clk), .rst(rst), .load(load), .opa_d(opa), .opb_d(opb),
        .sel_guard(g1), .sel_ext(e1)
    );

    function automatic bit uni(input logic [N-1:0] x, input int k);
        for (int i = 0; i <= k; i++)
            if (x[N-1-i] != x[N-1]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit fit_add(input logic [N-1:0] a, input logic [N-1:0] b);
        return uni(a, NM) && uni(b, NM);
    endfunction

    function automatic bit fit_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        int ka [3] = '{3, 4, 5};
        int kb [3] = '{5, 4, 3};
        for (int p = 0; p < 3; p++)
            if (uni(a, ka[p]) && uni(b, kb[p])) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    function automatic string gtag(input logic ld, input bit f);
        if (ld && f) return "R4 guard closes before edge";
        if (ld) return "R5 guard waits for edge";
        return "R7 idle guard";
    endfunction

    task automatic step(input logic ld, input logic [N-1:0] a, input logic [N-1:0] b);
        bit fm;
        bit fa;
        fm = fit_mul(a, b);
        fa = fit_add(a, b);
        @(negedge clk);
        load = ld; opa = a; opb = b;
        #2;
        chk({gtag(ld, fm), " mul"}, g0, (ld && fm) ? 1'b0 : s0);
        chk({gtag(ld, fa), " add"}, g1, (ld && fa) ? 1'b0 : s1);
        @(posedge clk);
        #2;
        if (ld) begin
            s0 = !fm;
            s1 = !fa;
        end
        chk(ld ? "R6 R3 mul decision" : "R7 mul hold", e0, s0);
        chk(ld ? "R6 R2 add decision" : "R7 add hold", e1, s1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset guard mul", g0, 1'b1);
        chk("R1 reset ext mul", e0, 1'b1);
        chk("R1 reset guard add", g1, 1'b1);
        chk("R1 reset ext add", e1, 1'b1);
        rst = 1'b0;

        foreach (VECS[i]) step(VECS[i].ld, VECS[i].a, VECS[i].b);

        // R5: close then try to open; guard stays low until the edge
        step(1'b1, 16'h0001, 16'h0002);
        step(1'b1, 16'h7000, 16'h0001);
        step(1'b1, 16'h0003, 16'hFFFE);

        // R7: idle cycles with wild operand changes keep the closed decision
        step(1'b0, 16'h8000, 16'h7FFF);
        step(1'b0, 16'h5555, 16'hAAAA);
        step(1'b0, 16'h0001, 16'h0001);

        // R3: only the first pair met, then only the last
        step(1'b1, 16'h0FFF, 16'h0300);
        step(1'b1, 16'h03FF, 16'h0FFF);
        step(1'b1, 16'h0FFF, 16'h0FFF);

        // R1: reset from a closed state restores full computation
        step(1'b1, 16'h0000, 16'hFFFF);
        @(negedge clk);
        load = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #2;
        s0 = 1; s1 = 1;
        chk("R1 mid-run reset ext mul", e0, 1'b1);
        chk("R1 mid-run reset ext add", e1, 1'b1);
        chk("R1 mid-run reset guard mul", g0, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 16'hFFFF, 16'h0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule